// File: doc/BRIEF.md
# Skewed Bank Address Mapper

The mapper places vector elements across a set of parallel memory modules so that strided sweeps spread over many modules. One request carries an element index together with a skew factor and a constant offset. The mapper returns the module that holds the element, computed as (skew * index + offset) reduced modulo the module count. It also returns the word slot inside that module, which is the index divided by the module count and rounded down.

The same request carries two stride operands and a pattern selector. From these the mapper derives an effective stride and decides whether a run of `ACCESS_LEN` elements at that stride would hit some module twice. The run is conflict-free exactly when the module count is at least the run length times gcd(module count, stride). The selector covers column, row, forward-diagonal and backward-diagonal walks through a matrix.

The module count need not be a power of two; a prime such as 17 is the intended use. Every modulo reduction is done by a serial restoring subtract against the constant module count. The gcd is found by a subtractive Euclid engine. Each request therefore takes a fixed number of cycles, and one request is in flight at a time.

Top module: `skew_bank_mapper`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0, `in_ready` is 1, and `out_module`, `out_addr` and `out_conflict` are 0.
- R2: On a result, `out_module` equals (in_skew * in_index + in_offset) mod NUM_MODULES, computed on the values present at acceptance. `out_module` never holds a value at or above NUM_MODULES.
- R3: On a result, `out_addr` equals floor(in_index / NUM_MODULES).
- R4: On a result, `out_conflict` is 1 exactly when ACCESS_LEN * gcd(NUM_MODULES, e mod NUM_MODULES) > NUM_MODULES, where gcd(M, 0) = M. The effective stride e comes from `in_pattern`: code 0 gives a, code 1 gives b, code 2 gives a+b, and code 3 gives |a-b|. Here a is `in_stride_a` and b is `in_stride_b`.
- R5: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` rises exactly LAT edges later and stays high for one cycle. LAT = max(IDX_W+SKEW_W+1, SKEW_W+2+2*NUM_MODULES) + 1.
- R6: `in_ready` is 0 from the accepting edge until the edge that raises `out_valid`, and is 1 again in the `out_valid` cycle. A request offered while `in_ready` is 0 is not taken and does not change the result in flight. If it is still offered, it is accepted on the first edge after `in_ready` returns.
- R7: While `out_valid` is 0, `out_module`, `out_addr` and `out_conflict` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Mapper idle, request can be taken |
| in_index | input | IDX_W | Element index i |
| in_skew | input | SKEW_W | Skew factor d |
| in_offset | input | SKEW_W | Constant offset C |
| in_stride_a | input | SKEW_W | First stride operand |
| in_stride_b | input | SKEW_W | Second stride operand |
| in_pattern | input | 2 | Effective stride select (0 a, 1 b, 2 a+b, 3 abs(a-b)) |
| out_valid | output | 1 | One-cycle result strobe |
| out_module | output | clog2(NUM_MODULES) | Module number |
| out_addr | output | IDX_W | Word slot inside the module |
| out_conflict | output | 1 | Strided run would revisit a module |

## Verification
A reducer that takes a wrong subtract decision on any step gives a wrong module number or slot in the same result strobe. The error often falls on one residue class only, so the index sweep walks every index against three skew and offset pairs. A gcd engine that stops early or swaps badly flips `out_conflict` for strides sharing a factor with the module count. Every pattern and stride pair in a small configuration is tried, so such a fault shows within one request. A controller counting one cycle off moves the strobe or leaves `in_ready` high during the busy window, and the bench watches every cycle of that window.

// File: rtl/skew_map_pkg.sv
package skew_map_pkg;

   // Selects which stride the conflict test applies.
   typedef enum logic [1:0] {
      PAT_A    = 2'd0,
      PAT_B    = 2'd1,
      PAT_SUM  = 2'd2,
      PAT_DIFF = 2'd3
   } stride_pat_e;

   // Fixed result latency: product reduction, or stride reduction plus
   // the worst-case subtractive gcd walk, plus one capture edge.
   function automatic int map_latency(input int prod_w, input int stride_w,
                                      input int modules);
      int gcd_path;
      gcd_path = stride_w + 1 + 2 * modules;
      return ((prod_w > gcd_path) ? prod_w : gcd_path) + 1;
   endfunction

endpackage

// File: rtl/skew_mod_reduce.sv
module skew_mod_reduce #(
   parameter int W = 8,
   parameter int M = 17
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [W-1:0]         x,
   output logic                 done,
   output logic [$clog2(M)-1:0] rem,
   output logic [W-1:0]         quo
);
   localparam int RW      = $clog2(M);
   localparam bit IS_POW2 = ((M & (M - 1)) == 0);

   if (M < 2) begin : g_bad_m
      $error("skew_mod_reduce: M must be at least 2");
   end
   if (W <= RW) begin : g_bad_w
      $error("skew_mod_reduce: W must exceed clog2(M)");
   end

   if (IS_POW2) begin : g_slice
      // Power-of-two count: remainder is a bit slice, one cycle.
      always_ff @(posedge clk) begin
         if (rst) begin
            rem  <= '0;
            quo  <= '0;
            done <= 1'b0;
         end else begin
            done <= start;
            if (start) begin
               rem <= x[RW-1:0];
               quo <= x >> RW;
            end
         end
      end
   end else begin : g_serial
      // Restoring reduction against the constant M, one bit per cycle,
      // MSB first; the partial remainder always stays below M.
      localparam int            CW    = $clog2(W + 1);
      localparam logic [RW:0]   M_VAL = (RW + 1)'(M);

      logic [W-1:0]  sh;
      logic [CW-1:0] cnt;
      logic          busy;
      logic [RW:0]   nxt;
      logic          ge;
      logic [RW-1:0] nxt_red;

      always_comb begin
         nxt     = {rem, sh[W-1]};
         ge      = (nxt >= M_VAL);
         nxt_red = ge ? RW'(nxt - M_VAL) : RW'(nxt);
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            rem  <= '0;
            quo  <= '0;
            done <= 1'b0;
         end else begin
            done <= 1'b0;
            if (start) begin
               sh   <= x;
               rem  <= '0;
               quo  <= '0;
               cnt  <= CW'(W);
               busy <= 1'b1;
            end else if (busy) begin
               rem <= nxt_red;
               quo <= {quo[W-2:0], ge};
               sh  <= sh << 1;
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/skew_gcd_unit.sv
module skew_gcd_unit #(
   parameter int M = 17
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [$clog2(M)-1:0]   b_in,
   output logic [$clog2(M+1)-1:0] g
);
   localparam int GW = $clog2(M + 1);

   logic [GW-1:0] a_q, b_q;

   // Subtractive Euclid on (M, b). It finishes in at most 2*M steps
   // and then parks with b = 0 and the gcd in a.
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= GW'(M);
         b_q <= '0;
      end else if (start) begin
         a_q <= GW'(M);
         b_q <= GW'(b_in);
      end else if (b_q != '0) begin
         if (a_q >= b_q) begin
            a_q <= a_q - b_q;
         end else begin
            a_q <= b_q;
            b_q <= a_q;
         end
      end
   end

   assign g = a_q;

endmodule

// File: rtl/skew_bank_mapper.sv
module skew_bank_mapper
   import skew_map_pkg::*;
#(
   parameter int NUM_MODULES = 17,
   parameter int IDX_W       = 16,
   parameter int SKEW_W      = 8,
   parameter int ACCESS_LEN  = 4,
   localparam int MOD_W      = $clog2(NUM_MODULES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IDX_W-1:0]  in_index,
   input  logic [SKEW_W-1:0] in_skew,
   input  logic [SKEW_W-1:0] in_offset,
   input  logic [SKEW_W-1:0] in_stride_a,
   input  logic [SKEW_W-1:0] in_stride_b,
   input  logic [1:0]        in_pattern,
   output logic              out_valid,
   output logic [MOD_W-1:0]  out_module,
   output logic [IDX_W-1:0]  out_addr,
   output logic              out_conflict
);
   localparam int P_W     = IDX_W + SKEW_W + 1;
   localparam int S_W     = SKEW_W + 1;
   localparam int G_W     = $clog2(NUM_MODULES + 1);
   localparam int LATENCY = map_latency(P_W, S_W, NUM_MODULES);
   localparam int CNT_W   = $clog2(LATENCY + 1);

   if (NUM_MODULES < 2) begin : g_bad_modules
      $error("skew_bank_mapper: NUM_MODULES must be at least 2");
   end
   if (ACCESS_LEN < 1) begin : g_bad_len
      $error("skew_bank_mapper: ACCESS_LEN must be at least 1");
   end
   if (IDX_W <= MOD_W || S_W <= MOD_W) begin : g_bad_width
      $error("skew_bank_mapper: operand widths too small for NUM_MODULES");
   end

   logic             accept;
   logic [P_W-1:0]   prod;
   logic [S_W-1:0]   eff_stride;
   logic [MOD_W-1:0] prod_rem, idx_rem, stride_rem;
   logic [P_W-1:0]   prod_quo;
   logic [IDX_W-1:0] idx_quo;
   logic [S_W-1:0]   stride_quo;
   logic             prod_done, idx_done, stride_done;
   logic [G_W-1:0]   gcd_val;
   logic             conflict_now;
   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             fire;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   // Skewed position before reduction.
   assign prod = P_W'(in_skew) * P_W'(in_index) + P_W'(in_offset);

   always_comb begin
      unique case (stride_pat_e'(in_pattern))
         PAT_A:    eff_stride = S_W'(in_stride_a);
         PAT_B:    eff_stride = S_W'(in_stride_b);
         PAT_SUM:  eff_stride = S_W'(in_stride_a) + S_W'(in_stride_b);
         PAT_DIFF: eff_stride = (in_stride_a >= in_stride_b)
                                ? S_W'(in_stride_a - in_stride_b)
                                : S_W'(in_stride_b - in_stride_a);
         default:  eff_stride = '0;
      endcase
   end

   skew_mod_reduce #(.W(P_W), .M(NUM_MODULES)) u_red_prod (
      .clk(clk), .rst(rst), .start(accept), .x(prod),
      .done(prod_done), .rem(prod_rem), .quo(prod_quo)
   );

   skew_mod_reduce #(.W(IDX_W), .M(NUM_MODULES)) u_red_index (
      .clk(clk), .rst(rst), .start(accept), .x(in_index),
      .done(idx_done), .rem(idx_rem), .quo(idx_quo)
   );

   skew_mod_reduce #(.W(S_W), .M(NUM_MODULES)) u_red_stride (
      .clk(clk), .rst(rst), .start(accept), .x(eff_stride),
      .done(stride_done), .rem(stride_rem), .quo(stride_quo)
   );

   skew_gcd_unit #(.M(NUM_MODULES)) u_gcd (
      .clk(clk), .rst(rst), .start(stride_done), .b_in(stride_rem),
      .g(gcd_val)
   );

   logic unused_bits;
   assign unused_bits = ^{prod_quo, idx_rem, stride_quo, prod_done, idx_done};

   assign conflict_now = (32'(ACCESS_LEN) * 32'(gcd_val)) > 32'(NUM_MODULES);

   // Fixed-latency sequencer: all engines have settled when it fires.
   assign fire = busy && (cnt == CNT_W'(LATENCY - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy         <= 1'b0;
         cnt          <= '0;
         out_valid    <= 1'b0;
         out_module   <= '0;
         out_addr     <= '0;
         out_conflict <= 1'b0;
      end else begin
         out_valid <= fire;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (fire) begin
            busy         <= 1'b0;
            out_module   <= prod_rem;
            out_addr     <= idx_quo;
            out_conflict <= conflict_now;
         end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/skew_map_checker.sv
module skew_map_checker #(
   parameter int NUM_MODULES = 17,
   parameter int MOD_W       = 5,
   parameter int IDX_W       = 16,
   parameter int LATENCY     = 40
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic [MOD_W-1:0] out_module,
   input logic [IDX_W-1:0] out_addr,
   input logic             out_conflict
);
   localparam int SW = $clog2(LATENCY + 2);

   // Edges since the last acceptance, saturating above LATENCY.
   logic [SW-1:0] since_acc;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_acc <= SW'(LATENCY + 1);
      end else if (in_valid && in_ready) begin
         since_acc <= '0;
      end else if (since_acc != SW'(LATENCY + 1)) begin
         since_acc <= since_acc + SW'(1);
      end
   end

   p_module_range_r2: assert property (@(posedge clk) disable iff (rst)
      {1'b0, out_module} < (MOD_W + 1)'(NUM_MODULES));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   p_fixed_latency_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (since_acc == SW'(LATENCY)));

   p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   p_ready_back_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_ready);

   p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_module) && $stable(out_addr)
                      && $stable(out_conflict)));

endmodule

bind skew_bank_mapper skew_map_checker #(
   .NUM_MODULES(NUM_MODULES),
   .MOD_W(MOD_W),
   .IDX_W(IDX_W),
   .LATENCY(LATENCY)
) u_checker (
   .clk(clk),
   .rst(rst),
   .in_valid(in_valid),
   .in_ready(in_ready),
   .out_valid(out_valid),
   .out_module(out_module),
   .out_addr(out_addr),
   .out_conflict(out_conflict)
);

// File: tb/tb_skew_bank_mapper.sv
module tb_skew_bank_mapper;
   localparam int M   = 6;
   localparam int IW  = 6;
   localparam int SW  = 4;
   localparam int N   = 3;
   localparam int MW  = $clog2(M);
   localparam int PW  = IW + SW + 1;
   localparam int T2  = SW + 2 + 2 * M;
   localparam int LAT = ((PW > T2) ? PW : T2) + 1;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic          in_ready;
   logic [IW-1:0] in_index;
   logic [SW-1:0] in_skew, in_offset, in_stride_a, in_stride_b;
   logic [1:0]    in_pattern;
   logic          out_valid;
   logic [MW-1:0] out_module;
   logic [IW-1:0] out_addr;
   logic          out_conflict;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   skew_bank_mapper #(.NUM_MODULES(M), .IDX_W(IW), .SKEW_W(SW),
                      .ACCESS_LEN(N)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_index(in_index), .in_skew(in_skew), .in_offset(in_offset),
      .in_stride_a(in_stride_a), .in_stride_b(in_stride_b),
      .in_pattern(in_pattern), .out_valid(out_valid),
      .out_module(out_module), .out_addr(out_addr),
      .out_conflict(out_conflict)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int gcd_ref(input int a, input int b);
      int x = a, y = b, t;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int eff_ref(input int a, input int b, input int pat);
      case (pat)
         0: return a;
         1: return b;
         2: return a + b;
         default: return (a >= b) ? a - b : b - a;
      endcase
   endfunction

   function automatic bit conf_ref(input int a, input int b, input int pat);
      return (N * gcd_ref(M, eff_ref(a, b, pat) % M)) > M;
   endfunction

   task automatic drive(input int idx, input int d, input int c,
                        input int a, input int b, input int pat);
      in_index    = IW'(idx);
      in_skew     = SW'(d);
      in_offset   = SW'(c);
      in_stride_a = SW'(a);
      in_stride_b = SW'(b);
      in_pattern  = 2'(pat);
   endtask

   task automatic check_result(input int idx, input int d, input int c,
                               input int a, input int b, input int pat);
      chk(out_valid === 1'b1, "R5", "strobe at LAT", out_valid, 1);
      chk(out_module == MW'((d * idx + c) % M), "R2", "module",
          out_module, (d * idx + c) % M);
      chk(out_addr == IW'(idx / M), "R3", "slot", out_addr, idx / M);
      chk(out_conflict == conf_ref(a, b, pat), "R4", "conflict",
          out_conflict, conf_ref(a, b, pat));
      chk(in_ready === 1'b1, "R6", "ready with strobe", in_ready, 1);
   endtask

   // One request from an idle mapper; every cycle of the wait is watched.
   task automatic run_one(input int idx, input int d, input int c,
                          input int a, input int b, input int pat);
      bit quiet;
      logic [MW-1:0] m_s;
      logic [IW-1:0] a_s;
      logic          c_s;
      while (in_ready !== 1'b1) @(negedge clk);
      drive(idx, d, c, a, b, pat);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      quiet = (out_valid === 1'b0) && (in_ready === 1'b0);
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         if (out_valid !== 1'b0 || in_ready !== 1'b0) quiet = 1'b0;
      end
      chk(quiet, "R6", "busy window (no early strobe, ready low)", !quiet, 0);
      @(negedge clk);
      check_result(idx, d, c, a, b, pat);
      m_s = out_module;
      a_s = out_addr;
      c_s = out_conflict;
      @(negedge clk);
      chk(out_valid === 1'b0 && out_module == m_s && out_addr == a_s
          && out_conflict == c_s, "R7", "hold after strobe", out_valid, 0);
   endtask

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      drive(0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "handshake in reset",
          {out_valid, in_ready}, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "valid after reset", out_valid, 0);
      chk(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);
      chk(out_module == '0 && out_addr == '0 && out_conflict == 1'b0, "R1",
          "outputs after reset", out_module + out_addr + out_conflict, 0);

      // R2 R3: every index against several skew/offset pairs
      for (int s = 0; s < 3; s++) begin
         for (int i = 0; i < 64; i++) begin
            int d, c;
            d = (s == 0) ? 1 : (s == 1) ? 5 : 15;
            c = (s == 0) ? 0 : (s == 1) ? 3 : 15;
            run_one(i, d, c, i % 16, (i * 7) % 16, i % 4);
         end
      end

      // R4: every stride pair under every pattern code
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            for (int p = 0; p < 4; p++) begin
               run_one((a * 16 + b) % 64, 7, 2, a, b, p);
            end
         end
      end

      // R6: a second request offered while busy must wait its turn
      begin
         int lat_seen;
         while (in_ready !== 1'b1) @(negedge clk);
         drive(41, 11, 4, 6, 3, 0);
         in_valid = 1'b1;
         @(posedge clk);
         @(negedge clk);
         drive(17, 3, 9, 4, 2, 3);
         lat_seen = 1;
         while (out_valid !== 1'b1 && lat_seen < LAT + 4) begin
            @(negedge clk);
            lat_seen++;
         end
         chk(lat_seen == LAT + 1, "R6", "first result timing under offer",
             lat_seen, LAT + 1);
         check_result(41, 11, 4, 6, 3, 0);
         @(negedge clk);
         in_valid = 1'b0;
         chk(in_ready === 1'b0, "R6", "held offer taken after strobe",
             in_ready, 0);
         chk(out_module == MW'((11 * 41 + 4) % M), "R7",
             "held result while next runs", out_module, (11 * 41 + 4) % M);
         repeat (LAT) @(negedge clk);
         check_result(17, 3, 9, 4, 2, 3);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   end

endmodule